// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block records a probe bus into an on-chip sample memory so that a host can later read back what happened inside the chip. A host issues short commands: start a capture at once, arm a capture that waits for a trigger, or stop. An external condition unit supplies a one-cycle trigger pulse and a qualify strobe. The controller keeps a chosen number of samples from before each trigger, so the record shows both what led up to the event and what followed it.

The memory can be split into 1, 2 or 4 equal windows. Windows fill one after another, and in triggered mode each window waits for its own trigger. In every window the controller writes to a circular position until the trigger comes. For each window it keeps the memory address where the trigger landed and how many samples from before the trigger are valid. With these values the host can put the window back into time order. When auto re-arm is on, the controller restarts as soon as the last window is full and keeps doing so until it is stopped. In qualified mode, a cycle is written to memory only when the qualify strobe is high.

Top module: `la_capture`

## Requirements
- R1: While reset is high and on the first cycle after it, status is idle (0), the window index is 0 and the done flag is low. Every window record reads back as address 0 with a pre-trigger count of 0.
- R2: The immediate command (`cmd_op_i` = 2) puts status into filling (2) on the next cycle. Each window then stores window-length samples at consecutive addresses from its base (window index × window length) without waiting for a trigger. Each record holds the window base and a count of 0.
- R3: The arm command (`cmd_op_i` = 1) puts status into waiting (1). Status stays waiting until a cycle in which `trig_i` is high. During the wait, stored samples advance a write offset that wraps inside the window.
- R4: On a trigger, the window record takes the absolute address the trigger-cycle sample goes to and the pre-trigger count. The programmed pre-trigger count `cfg_pre_i` is clamped to window length − 1. The window then takes exactly window length − count more stored samples, and the trigger-cycle sample is the first of them.
- R5: If a trigger arrives before the programmed pre-trigger count has been stored, it is still accepted. The record holds the number of samples actually stored since the window opened, and the window then stores window length minus that number.
- R6: `cfg_win_log2_i` = n (clamped to 2) gives 2^n windows of 64 >> n samples. Windows fill in increasing index order. `win_o` shows the window being filled or awaited, and steps by one when a window completes.
- R7: When the last window completes and auto re-arm is off, status returns to idle and `done_o` goes high. `done_o` stays high until the next arm or immediate command, which clears it.
- R8: With `cfg_auto_i` set at the command, completion of the last window sets `done_o` and restarts at window 0 in the same mode. This repeats until a stop command.
- R9: With `cfg_qual_i` set at the command, a cycle with `qual_i` low writes nothing, does not advance the write offset, and does not count toward pre-trigger or post-trigger totals.
- R10: The stop command (`cmd_op_i` = 3) returns status to idle on the next cycle from any state, clears auto re-arm and leaves `done_o` unchanged. `cmd_op_i` = 0 with `cmd_valid_i` high has no effect.
- R11: `rd_data_o` shows the memory word at `rd_addr_i` one cycle after the address is presented, and the window record output follows `info_sel_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | 8 | Probe bus to record |
| trig_i | input | 1 | Trigger pulse from the condition unit |
| qual_i | input | 1 | Sample qualify strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 none, 1 arm, 2 immediate, 3 stop |
| cfg_win_log2_i | input | 2 | log2 of the window count, taken at a command |
| cfg_pre_i | input | 6 | Pre-trigger sample count, taken at a command |
| cfg_auto_i | input | 1 | Auto re-arm enable, taken at a command |
| cfg_qual_i | input | 1 | Qualified storage enable, taken at a command |
| rd_addr_i | input | 6 | Memory read address |
| info_sel_i | input | 2 | Window record select |
| rd_data_o | output | 8 | Memory read data, one-cycle latency |
| info_trig_o | output | 6 | Trigger address of the selected window |
| info_pre_o | output | 6 | Valid pre-trigger count of the selected window |
| state_o | output | 2 | 0 idle, 1 waiting, 2 filling |
| win_o | output | 2 | Current window index |
| done_o | output | 1 | Last window completed |

## Verification
A wrong remaining-sample count or write offset shows up on `state_o` and `win_o` as soon as a window ends one cycle early or late. It shows up again at readout, as a memory word or trigger address that does not match. A miscount in the pre-trigger fill shows up on `info_pre_o` once the trigger cycle has passed, and it moves the end of that window. A lost qualify gate changes the stored words and makes every later window end at the wrong cycle. For this reason status, window index, record outputs and read data are compared with an independent model on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

    localparam int PROBE_W  = 8;
    localparam int ADDR_W   = 6;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int WLOG_MAX = 2;
    localparam int WIN_MAX  = 1 << WLOG_MAX;
    localparam int WIN_W    = (WLOG_MAX > 0) ? WLOG_MAX : 1;
    localparam int NLOG_W   = $clog2(WLOG_MAX + 1);

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [ADDR_W:0]    cnt_t;
    typedef logic [PROBE_W-1:0] sample_t;
    typedef logic [WIN_W-1:0]   win_t;
    typedef logic [NLOG_W-1:0]  nlog_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FILL = 2'd2
    } cap_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ARM  = 2'd1,
        OP_NOW  = 2'd2,
        OP_STOP = 2'd3
    } cap_op_e;

    typedef struct packed {
        nlog_t nlog;
        addr_t pre;
        logic  auto_rearm;
        logic  qual_en;
        logic  immediate;
    } cfg_t;

    typedef struct packed {
        logic    en;
        addr_t   addr;
        sample_t data;
    } wr_t;

    typedef struct packed {
        addr_t trig;
        addr_t pre_cnt;
    } win_rec_t;

    typedef struct packed {
        cap_state_e st;
        win_t       win;
        cnt_t       wp;
        cnt_t       pf;
        cnt_t       rem;
        logic       done;
        cfg_t       cfg;
    } ctl_t;

    localparam cnt_t CNT_ONE = cnt_t'(1);

    function automatic cnt_t win_len(nlog_t n);
        return cnt_t'(DEPTH) >> n;
    endfunction

    function automatic addr_t win_base(win_t w, nlog_t n);
        addr_t b;
        b = addr_t'(w);
        return b << (ADDR_W - int'(n));
    endfunction

    function automatic win_t last_win(nlog_t n);
        return win_t'((1 << n) - 1);
    endfunction

    function automatic cfg_t make_cfg(nlog_t n_raw, addr_t pre_raw,
                                      logic auto_r, logic qual, logic imm);
        cfg_t c;
        cnt_t len;
        c.nlog       = (n_raw > nlog_t'(WLOG_MAX)) ? nlog_t'(WLOG_MAX) : n_raw;
        len          = win_len(c.nlog);
        c.pre        = ({1'b0, pre_raw} >= len) ? addr_t'(len - CNT_ONE) : pre_raw;
        c.auto_rearm = auto_r;
        c.qual_en    = qual;
        c.immediate  = imm;
        return c;
    endfunction

    function automatic ctl_t open_win(ctl_t c, win_t w);
        ctl_t r;
        r     = c;
        r.win = w;
        r.wp  = '0;
        r.pf  = '0;
        r.rem = win_len(c.cfg.nlog);
        r.st  = c.cfg.immediate ? ST_FILL : ST_WAIT;
        return r;
    endfunction

endpackage

// File: rtl/la_cap_mem.sv
module la_cap_mem
    import la_cap_pkg::*;
(
    input  logic    clk,
    input  wr_t     wr_i,
    input  addr_t   rd_addr_i,
    output sample_t rd_data_o
);

    sample_t store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_i.en) begin
            store_q[wr_i.addr] <= wr_i.data;
        end
        rd_data_o <= store_q[rd_addr_i];
    end

endmodule

// File: rtl/la_cap_rec.sv
module la_cap_rec
    import la_cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  win_t     idx_i,
    input  win_rec_t rec_i,
    input  win_t     sel_i,
    output win_rec_t rec_o
);

    win_rec_t recs_q [WIN_MAX];

    for (genvar g = 0; g < WIN_MAX; g++) begin : g_rec
        always_ff @(posedge clk) begin
            if (rst) begin
                recs_q[g] <= '0;
            end else if (we_i && (idx_i == win_t'(g))) begin
                recs_q[g] <= rec_i;
            end
        end
    end

    assign rec_o = recs_q[sel_i];

endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm
    import la_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid_i,
    input  cap_op_e    cmd_op_i,
    input  cfg_t       cfg_i,
    input  logic       trig_i,
    input  logic       qual_i,
    input  sample_t    probe_i,
    output wr_t        wr_o,
    output logic       rec_we_o,
    output win_t       rec_idx_o,
    output win_rec_t   rec_o,
    output cap_state_e state_o,
    output win_t       win_o,
    output logic       done_o
);

    ctl_t  q, d;
    cnt_t  len, rem_cur;
    addr_t base;
    logic  store, filling, opened;

    always_comb begin
        d         = q;
        opened    = 1'b0;
        rec_we_o  = 1'b0;
        rec_idx_o = q.win;
        rec_o     = '0;
        wr_o      = '0;
        len       = win_len(q.cfg.nlog);
        base      = win_base(q.win, q.cfg.nlog);
        store     = !q.cfg.qual_en || qual_i;
        filling   = (q.st == ST_FILL);
        rem_cur   = q.rem;

        if (cmd_valid_i && (cmd_op_i == OP_ARM || cmd_op_i == OP_NOW)) begin
            d.cfg  = cfg_i;
            d.done = 1'b0;
            d      = open_win(d, '0);
            opened = 1'b1;
        end else if (cmd_valid_i && cmd_op_i == OP_STOP) begin
            d.st             = ST_IDLE;
            d.cfg.auto_rearm = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (q.st == ST_WAIT && trig_i) begin
                // trigger: the rest of the window is post-trigger storage
                filling           = 1'b1;
                rem_cur           = len - q.pf;
                d.st              = ST_FILL;
                d.rem             = rem_cur;
                rec_we_o          = 1'b1;
                rec_o.trig        = base + q.wp[ADDR_W-1:0];
                rec_o.pre_cnt     = q.pf[ADDR_W-1:0];
            end
            if (store) begin
                wr_o.en   = 1'b1;
                wr_o.addr = base + q.wp[ADDR_W-1:0];
                wr_o.data = probe_i;
                d.wp      = ((q.wp + CNT_ONE) == len) ? '0 : (q.wp + CNT_ONE);
                if (!filling) begin
                    if (q.pf < {1'b0, q.cfg.pre}) begin
                        d.pf = q.pf + CNT_ONE;
                    end
                end else if (rem_cur == CNT_ONE) begin
                    if (q.win != last_win(q.cfg.nlog)) begin
                        d      = open_win(d, q.win + win_t'(1));
                        opened = 1'b1;
                    end else begin
                        d.done = 1'b1;
                        if (d.cfg.auto_rearm) begin
                            d      = open_win(d, '0);
                            opened = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end else begin
                    d.rem = rem_cur - CNT_ONE;
                end
            end
        end

        // an immediate window starts at its base with no pre-trigger part
        if (opened && d.cfg.immediate) begin
            rec_we_o      = 1'b1;
            rec_idx_o     = d.win;
            rec_o.trig    = win_base(d.win, d.cfg.nlog);
            rec_o.pre_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;
    assign win_o   = q.win;
    assign done_o  = q.done;

endmodule

// File: rtl/la_capture.sv
module la_capture
    import la_cap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PROBE_W-1:0]  probe_i,
    input  logic                trig_i,
    input  logic                qual_i,
    input  logic                cmd_valid_i,
    input  logic [1:0]          cmd_op_i,
    input  logic [NLOG_W-1:0]   cfg_win_log2_i,
    input  logic [ADDR_W-1:0]   cfg_pre_i,
    input  logic                cfg_auto_i,
    input  logic                cfg_qual_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic [WIN_W-1:0]    info_sel_i,
    output logic [PROBE_W-1:0]  rd_data_o,
    output logic [ADDR_W-1:0]   info_trig_o,
    output logic [ADDR_W-1:0]   info_pre_o,
    output logic [1:0]          state_o,
    output logic [WIN_W-1:0]    win_o,
    output logic                done_o
);

    cap_op_e    op;
    cfg_t       cfg;
    wr_t        wr;
    logic       rec_we;
    win_t       rec_idx;
    win_rec_t   rec_in, rec_out;
    cap_state_e st;

    assign op  = cap_op_e'(cmd_op_i);
    assign cfg = make_cfg(cfg_win_log2_i, cfg_pre_i, cfg_auto_i, cfg_qual_i,
                          op == OP_NOW);

    la_cap_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (op),
        .cfg_i       (cfg),
        .trig_i      (trig_i),
        .qual_i      (qual_i),
        .probe_i     (probe_i),
        .wr_o        (wr),
        .rec_we_o    (rec_we),
        .rec_idx_o   (rec_idx),
        .rec_o       (rec_in),
        .state_o     (st),
        .win_o       (win_o),
        .done_o      (done_o)
    );

    la_cap_mem u_mem (
        .clk       (clk),
        .wr_i      (wr),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    la_cap_rec u_rec (
        .clk   (clk),
        .rst   (rst),
        .we_i  (rec_we),
        .idx_i (rec_idx),
        .rec_i (rec_in),
        .sel_i (info_sel_i),
        .rec_o (rec_out)
    );

    assign state_o     = st;
    assign info_trig_o = rec_out.trig;
    assign info_pre_o  = rec_out.pre_cnt;

endmodule

// File: rtl/la_cap_chk.sv
module la_cap_chk
    import la_cap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid_i,
    input logic [1:0]       cmd_op_i,
    input logic             trig_i,
    input logic [1:0]       state_o,
    input logic [WIN_W-1:0] win_o,
    input logic             done_o
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == 2'd0) && !done_o && (win_o == '0));

    assert_now_fills_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_op_i == 2'd2) |=> (state_o == 2'd2));

    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && !trig_i && !cmd_valid_i) |=> (state_o == 2'd1));

    assert_win_step_R6: assert property (@(posedge clk) disable iff (rst)
        ((win_o != $past(win_o)) && !$past(cmd_valid_i))
            |-> ((win_o == $past(win_o) + 1'b1) || (win_o == '0)));

    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_op_i == 2'd1)
            |=> (state_o == 2'd1) && !done_o && (win_o == '0));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_op_i == 2'd3) |=> (state_o == 2'd0));

endmodule

bind la_capture la_cap_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .trig_i      (trig_i),
    .state_o     (state_o),
    .win_o       (win_o),
    .done_o      (done_o)
);

// File: tb/la_capture_tb.sv
module la_capture_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] probe = 8'd0;
    logic       trig = 1'b0, qual = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cfg_nlog = 2'd0;
    logic [5:0] cfg_pre = 6'd0;
    logic       cfg_auto = 1'b0, cfg_qual = 1'b0;
    logic [5:0] rd_addr = 6'd0;
    logic [1:0] info_sel = 2'd0;
    logic [7:0] rd_data;
    logic [5:0] info_trig, info_pre;
    logic [1:0] state;
    logic [1:0] win;
    logic       done;

    int    nchk = 0, nerr = 0;
    string cur_req = "R1";
    bit    qual_rand = 0;
    logic [7:0] lfsr = 8'hA5;

    // reference model state
    int mS, mWin, mDone, mWp, mPf, mRem, mN, mPre, mAuto, mQual, mImm;
    int mtrig [4];
    int mprev [4];
    int mmem  [64];
    bit mval  [64];
    int mrd;
    bit mrdv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    la_capture u_dut (
        .clk            (clk),
        .rst            (rst),
        .probe_i        (probe),
        .trig_i         (trig),
        .qual_i         (qual),
        .cmd_valid_i    (cmd_valid),
        .cmd_op_i       (cmd_op),
        .cfg_win_log2_i (cfg_nlog),
        .cfg_pre_i      (cfg_pre),
        .cfg_auto_i     (cfg_auto),
        .cfg_qual_i     (cfg_qual),
        .rd_addr_i      (rd_addr),
        .info_sel_i     (info_sel),
        .rd_data_o      (rd_data),
        .info_trig_o    (info_trig),
        .info_pre_o     (info_pre),
        .state_o        (state),
        .win_o          (win),
        .done_o         (done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic m_open();
        mWp = 0;
        mPf = 0;
        if (mImm != 0) begin
            mS   = 2;
            mRem = 64 >> mN;
            mtrig[mWin] = mWin * (64 >> mN);
            mprev[mWin] = 0;
        end else begin
            mS = 1;
        end
    endtask

    task automatic m_win_done();
        if (mWin < (1 << mN) - 1) begin
            mWin++;
            m_open();
        end else begin
            mDone = 1;
            if (mAuto != 0) begin
                mWin = 0;
                m_open();
            end else begin
                mS = 0;
            end
        end
    endtask

    // behavioural model, stepped on every rising edge
    always @(posedge clk) begin : model
        int L, base, remc;
        bit st, filling;
        mrd  = mmem[rd_addr];
        mrdv = mval[rd_addr];
        if (rst) begin
            mS = 0; mWin = 0; mDone = 0; mWp = 0; mPf = 0; mRem = 0;
            mN = 0; mPre = 0; mAuto = 0; mQual = 0; mImm = 0;
            for (int i = 0; i < 4; i++) begin mtrig[i] = 0; mprev[i] = 0; end
        end else if (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2)) begin
            mN    = (cfg_nlog > 2) ? 2 : int'(cfg_nlog);
            L     = 64 >> mN;
            mPre  = (cfg_pre >= L) ? L - 1 : int'(cfg_pre);
            mAuto = cfg_auto;
            mQual = cfg_qual;
            mImm  = (cmd_op == 2'd2);
            mWin  = 0;
            mDone = 0;
            m_open();
        end else if (cmd_valid && cmd_op == 2'd3) begin
            mS    = 0;
            mAuto = 0;
        end else if (mS != 0) begin
            L       = 64 >> mN;
            base    = mWin * L;
            st      = (mQual != 0) ? qual : 1'b1;
            filling = (mS == 2);
            remc    = mRem;
            if (mS == 1 && trig) begin
                filling = 1;
                remc    = L - mPf;
                mS      = 2;
                mRem    = remc;
                mtrig[mWin] = base + mWp;
                mprev[mWin] = mPf;
            end
            if (st) begin
                mmem[base + mWp] = probe;
                mval[base + mWp] = 1;
                mWp = (mWp + 1) % L;
                if (!filling) begin
                    if (mPf < mPre) mPf++;
                end else if (remc == 1) begin
                    m_win_done();
                end else begin
                    mRem = remc - 1;
                end
            end
        end
    end

    // compare every port against the model between edges
    always @(negedge clk) begin
        if (!rst) begin
            chk(state == mS[1:0], cur_req, "status", state, mS);
            chk(win == mWin[1:0], cur_req, "window index", win, mWin);
            chk(done == mDone[0], cur_req, "done flag", done, mDone);
            chk(info_trig == mtrig[info_sel][5:0], "R4", "record trigger address",
                info_trig, mtrig[info_sel]);
            chk(info_pre == mprev[info_sel][5:0], "R5", "record pre-trigger count",
                info_pre, mprev[info_sel]);
            if (mrdv) chk(rd_data == mrd[7:0], "R11", "read data", rd_data, mrd);
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            probe = probe + 8'd1;
            lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            qual  = qual_rand ? lfsr[0] : 1'b1;
        end
    endtask

    task automatic cmd(logic [1:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        tick(1);
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        tick(1);
        trig = 1'b0;
    endtask

    task automatic read_all();
        for (int a = 0; a < 64; a++) begin
            rd_addr = a[5:0];
            tick(1);
        end
        tick(1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        nerr++;
        $display("FAIL watchdog over all requirements: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin : stim
        tick(3);
        @(negedge clk);
        // R1: reset state at the ports
        chk(state == 2'd0, "R1", "status in reset", state, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(win == 2'd0, "R1", "window in reset", win, 0);
        rst = 1'b0;
        tick(2);
        chk(info_trig == 6'd0 && info_pre == 6'd0, "R1", "record after reset",
            info_trig, 0);

        // R2 R7 R11: immediate capture, one window
        cur_req = "R2";
        cfg_nlog = 2'd0; cfg_pre = 6'd0; cfg_auto = 0; cfg_qual = 0;
        cmd(2'd2);
        tick(70);
        cur_req = "R7";
        chk(state == 2'd0 && done == 1'b1, "R7", "idle with done", state, 0);
        read_all();

        // R3 R4: triggered capture with 8 pre-trigger samples
        cur_req = "R3";
        cfg_pre = 6'd8;
        cmd(2'd1);
        tick(20);
        chk(state == 2'd1, "R3", "still waiting", state, 1);
        pulse_trig();
        tick(70);
        chk(info_pre == 6'd8, "R4", "pre-trigger count", info_pre, 8);
        read_all();

        // R5: trigger before the pre-trigger part is full
        cur_req = "R5";
        cfg_pre = 6'd20;
        cmd(2'd1);
        tick(4);
        pulse_trig();
        tick(70);
        chk(info_pre == 6'd4, "R5", "early trigger count", info_pre, 4);
        read_all();

        // R6: four windows of 16, one trigger each
        cur_req = "R6";
        cfg_nlog = 2'd2; cfg_pre = 6'd4;
        cmd(2'd1);
        for (int w = 0; w < 4; w++) begin
            tick(10 + w);
            pulse_trig();
            tick(20);
        end
        for (int s = 0; s < 4; s++) begin
            info_sel = s[1:0];
            tick(1);
        end
        read_all();

        // R9: qualified storage, two windows
        cur_req = "R9";
        cfg_nlog = 2'd1; cfg_pre = 6'd6; cfg_qual = 1;
        qual_rand = 1;
        cmd(2'd1);
        tick(30);
        pulse_trig();
        tick(90);
        pulse_trig();
        tick(120);
        qual_rand = 0;
        cfg_qual = 0;
        info_sel = 2'd0; tick(1);
        info_sel = 2'd1; tick(1);
        read_all();

        // R4 clamp and R10 stop while waiting
        cur_req = "R10";
        cfg_nlog = 2'd2; cfg_pre = 6'd63;
        cmd(2'd1);
        tick(30);
        pulse_trig();
        info_sel = 2'd0;
        tick(3);
        chk(info_pre == 6'd15, "R4", "clamped pre-trigger count", info_pre, 15);
        chk(state == 2'd1 && win == 2'd1, "R4", "window ended on trigger", win, 1);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        tick(1);
        cmd_valid = 1'b0;
        cmd(2'd3);
        chk(state == 2'd0, "R10", "idle after stop", state, 0);
        tick(3);

        // R8: auto re-arm in immediate mode until stop
        cur_req = "R8";
        cfg_nlog = 2'd1; cfg_auto = 1;
        cmd(2'd2);
        tick(150);
        chk(state == 2'd2 && done == 1'b1, "R8", "restarted after last window", state, 2);
        cmd(2'd3);
        cfg_auto = 0;
        tick(3);
        chk(state == 2'd0 && done == 1'b1, "R10", "stop keeps done", state, 0);

        // R7: arming clears done
        cur_req = "R7";
        cmd(2'd1);
        chk(done == 1'b0 && state == 2'd1, "R7", "arm clears done", done, 0);
        cmd(2'd3);
        tick(3);

        summary();
        $finish;
    end

endmodule